// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front-End

This block models the host side of an asynchronous parallel NOR flash device together with a small storage array. It decodes four active-low bus pins (chip select, output enable, write enable and a device reset) into four bus modes: read, output disable, standby and write. In read mode it drives a 16-bit word onto the data bus. An output-enable signal stands in for tri-state drivers, so that the block stays synthesizable.

A write cycle ends when the first strobe deasserts: write enable rising or chip select rising. That edge captures the address and data. The strobes are asynchronous to the system clock and pass through two-flop synchronizers. A small command interpreter turns the captured writes into program and block-erase operations. A program can only clear bits. An erase returns a whole block to all ones. Both run for a fixed number of clocks with a busy flag raised. The operation keeps running if the device is deselected. Writes that arrive while busy are dropped.

Top module: `flash_bus_frontend`

## Requirements
- R1: After reset every one of the 64 words reads 0xFFFF, busy_o is low, and data_oe_o is low while the bus pins are idle.
- R2: data_oe_o is high only when ce_ni=0, oe_ni=0, we_ni=1 and dev_rst_ni=1. In that case data_o equals the stored word at addr_i, with no clock latency.
- R3: With ce_ni=0 and oe_ni=1 (output disable), data_oe_o is low.
- R4: With ce_ni=1 (standby), data_oe_o is low whatever the state of oe_ni.
- R5: A write requires ce_ni=0, we_ni=0 and dev_rst_ni=1. Its address and data are those held when the first of we_ni or ce_ni rises, and either strobe may end the cycle.
- R6: A write whose low byte is 0x40, followed by a second write, programs the second write's address. The new word is the old word AND the written data, so no bit returns from 0 to 1.
- R7: A write with low byte 0x20 followed by a write with low byte 0xD0 erases the block selected by address bits [5:4] of the second write. All 16 words of that block become 0xFFFF, and the other blocks are unchanged.
- R8: A 0x20 write followed by any low byte other than 0xD0 abandons the erase, and the array is unchanged.
- R9: busy_o rises three clock edges after the strobe that ends the command's final write. It stays high for exactly 4 cycles for a program and 16 cycles for an erase. The array update is visible once busy_o falls.
- R10: Writes that complete while busy_o is high are ignored. A 0x40 sent during busy does not arm a program.
- R11: Deselecting the device during an operation neither stops nor lengthens it. data_oe_o stays low throughout the standby.
- R12: A read-array write (low byte 0xFF) or an unrecognised code leaves every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, erases array to ones |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| dev_rst_ni | input | 1 | Device reset pin, active low; blocks reads and writes |
| addr_i | input | 6 | Word address |
| data_i | input | 16 | Write data bus |
| data_o | output | 16 | Read data bus |
| data_oe_o | output | 1 | High when data_o is driven |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The read path is combinational. The bench therefore applies pin and address changes on a falling clock edge and samples data_oe_o and data_o one nanosecond later. After the strobe that ends a write, busy_o is due on the third rising edge. The bench counts busy_o samples on falling edges until the flag drops, and compares the total with 4 or 16. Array contents are read only after busy_o has fallen. Reads check every word against a model that the bench updates with AND for programs and with all ones for erased blocks.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  typedef enum logic [1:0] {CS_IDLE, CS_PGM, CS_ERS, CS_BUSY} cmd_state_e;
  typedef enum logic [1:0] {BUS_READ, BUS_ODIS, BUS_STBY, BUS_WRITE} bus_mode_e;
  localparam logic [7:0] OP_PROGRAM = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_READ    = 8'hFF;
endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/flash_fe_cmd.sv
module flash_fe_cmd
  import flash_fe_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int PGM_CYC = 4,
  parameter int ERS_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          busy_o,
  output logic          pgm_commit_o,
  output logic          ers_commit_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);
  localparam int CW = $clog2(ERS_CYC + 1);

  cmd_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          is_ers_q;
  logic [7:0]    code;

  assign code = wr_data_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CS_IDLE;
      cnt_q     <= '0;
      is_ers_q  <= 1'b0;
      op_addr_o <= '0;
      op_data_o <= '0;
    end else begin
      unique case (state_q)
        CS_IDLE: if (fire_i) begin
          if (code == OP_PROGRAM)    state_q <= CS_PGM;
          else if (code == OP_ERASE) state_q <= CS_ERS;
        end
        CS_PGM: if (fire_i) begin
          op_addr_o <= wr_addr_i;
          op_data_o <= wr_data_i;
          is_ers_q  <= 1'b0;
          cnt_q     <= CW'(PGM_CYC - 1);
          state_q   <= CS_BUSY;
        end
        CS_ERS: if (fire_i) begin
          if (code == OP_CONFIRM) begin
            op_addr_o <= wr_addr_i;
            is_ers_q  <= 1'b1;
            cnt_q     <= CW'(ERS_CYC - 1);
            state_q   <= CS_BUSY;
          end else begin
            state_q <= CS_IDLE;
          end
        end
        CS_BUSY: begin
          // writes landing here are dropped
          if (cnt_q == '0) state_q <= CS_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q == CS_BUSY);
  assign pgm_commit_o = busy_o && (cnt_q == '0) && !is_ers_q;
  assign ers_commit_o = busy_o && (cnt_q == '0) && is_ers_q;
endmodule

// File: rtl/flash_fe_array.sv
module flash_fe_array #(
  parameter int DW        = 16,
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 16,
  parameter int AW        = $clog2(NUM_BLK * BLK_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pgm_i,
  input  logic          ers_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] op_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = NUM_BLK * BLK_WORDS;
  localparam int BB    = $clog2(BLK_WORDS);

  logic [DW-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [AW-1:0] WA = AW'(w);
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      word_q <= '1;
      else if (pgm_i && op_addr_i == WA)                word_q <= word_q & op_data_i;
      else if (ers_i && op_addr_i[AW-1:BB] == WA[AW-1:BB]) word_q <= '1;
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 16,
  parameter int PGM_CYC   = 4,
  parameter int ERS_CYC   = 16,
  parameter int AW        = $clog2(NUM_BLK * BLK_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          dev_rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          busy_o
);
  bus_mode_e     mode;
  logic          wr_act_raw, wr_act_s, wr_act_prev_q, fire;
  logic [AW+DW-1:0] bus_s, hold_q;
  logic          pgm_commit, ers_commit;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, rd_data;

  always_comb begin
    if (ce_ni)                     mode = BUS_STBY;
    else if (!we_ni)               mode = BUS_WRITE;
    else if (!oe_ni && dev_rst_ni) mode = BUS_READ;
    else                           mode = BUS_ODIS;
  end

  assign wr_act_raw = (mode == BUS_WRITE) && dev_rst_ni;

  flash_fe_sync #(.W(1)) u_sync_act (
    .clk_i, .rst_ni, .d_i(wr_act_raw), .q_o(wr_act_s)
  );
  flash_fe_sync #(.W(AW + DW)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({addr_i, data_i}), .q_o(bus_s)
  );

  // hold the last address/data seen while the cycle was active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_prev_q <= 1'b0;
      hold_q        <= '0;
    end else begin
      wr_act_prev_q <= wr_act_s;
      if (wr_act_s) hold_q <= bus_s;
    end
  end
  assign fire = wr_act_prev_q && !wr_act_s;

  flash_fe_cmd #(
    .AW(AW), .DW(DW), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)
  ) u_cmd (
    .clk_i, .rst_ni,
    .fire_i      (fire),
    .wr_addr_i   (hold_q[AW+DW-1:DW]),
    .wr_data_i   (hold_q[DW-1:0]),
    .busy_o      (busy_o),
    .pgm_commit_o(pgm_commit),
    .ers_commit_o(ers_commit),
    .op_addr_o   (op_addr),
    .op_data_o   (op_data)
  );

  flash_fe_array #(
    .DW(DW), .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS), .AW(AW)
  ) u_array (
    .clk_i, .rst_ni,
    .pgm_i    (pgm_commit),
    .ers_i    (ers_commit),
    .op_addr_i(op_addr),
    .op_data_i(op_data),
    .rd_addr_i(addr_i),
    .rd_data_o(rd_data)
  );

  assign data_oe_o = (mode == BUS_READ);
  assign data_o    = data_oe_o ? rd_data : '0;
endmodule

// File: rtl/flash_fe_chk.sv
module flash_fe_chk #(
  parameter int PGM_CYC = 4,
  parameter int ERS_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_ni,
  input logic oe_ni,
  input logic we_ni,
  input logic dev_rst_ni,
  input logic data_oe_o,
  input logic busy_o
);
  localparam int RW = $clog2(ERS_CYC + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R2
  read_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !oe_ni && we_ni && dev_rst_ni));
  // R3
  out_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |-> !data_oe_o);
  // R4
  standby_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o);
  // R9
  busy_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  // R9
  busy_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < RW'(ERS_CYC)));
endmodule

bind flash_bus_frontend flash_fe_chk #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
  .dev_rst_ni(dev_rst_ni), .data_oe_o(data_oe_o), .busy_o(busy_o)
);

// File: tb/flash_bus_frontend_tb.sv
module flash_bus_frontend_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dr_n = 1'b1;
  logic [5:0]  addr = '0;
  logic [15:0] din = '0, dout;
  logic doe, busy;
  logic [15:0] exp_mem [64];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  flash_bus_frontend u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .dev_rst_ni(dr_n), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d, input bit by_ce);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk);
    if (by_ce) begin ce_n = 1'b1; @(negedge clk); we_n = 1'b1; end
    else       begin we_n = 1'b1; @(negedge clk); ce_n = 1'b1; end
    @(negedge clk);
  endtask

  task automatic wait_busy(input int exp_len, input string req, output bit oe_seen);
    int cnt = 0;
    oe_seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (doe) oe_seen = 1'b1;
      if (busy) cnt++;
      else if (cnt > 0) break;
    end
    if (exp_len >= 0) chk(req, cnt, exp_len);
  endtask

  task automatic rd(input logic [5:0] a, input string req);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    chk(req, {15'd0, doe, dout}, {15'd0, 1'b1, exp_mem[a]});
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd_all(input string req);
    for (int a = 0; a < 64; a++) rd(6'(a), req);
  endtask

  task automatic program_word(input logic [5:0] a, input logic [15:0] d, input bit by_ce, input string req);
    bit s;
    bus_wr(a, 16'h0040, 1'b0);
    bus_wr(a, d, by_ce);
    wait_busy(4, "R9", s);
    exp_mem[a] = exp_mem[a] & d;
  endtask

  task automatic erase_blk(input logic [5:0] a);
    bit s;
    bus_wr(a, 16'h0020, 1'b0);
    bus_wr(a, 16'h00D0, 1'b0);
    wait_busy(16, "R9", s);
    for (int w = 0; w < 16; w++) exp_mem[{a[5:4], 4'(w)}] = 16'hFFFF;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit s;
    for (int a = 0; a < 64; a++) exp_mem[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 oe idle", doe, 0);
    rd_all("R1");

    // R3 output disable, R4 standby with oe low, R2 gating by dev reset
    @(negedge clk); ce_n = 0; oe_n = 1; #1; chk("R3", doe, 0);
    @(negedge clk); ce_n = 1; oe_n = 0; #1; chk("R4", doe, 0);
    @(negedge clk); ce_n = 0; oe_n = 0; dr_n = 0; #1; chk("R2 dev reset", doe, 0);
    @(negedge clk); dr_n = 1; din = 16'h00FF; we_n = 0; #1; chk("R2 we low", doe, 0);
    @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
    repeat (4) @(negedge clk);
    rd_all("R12 after 0xFF");

    // R5/R6: program every word, alternating the ending strobe
    for (int a = 0; a < 64; a++)
      program_word(6'(a), 16'(a * 16'h1357) ^ 16'hA5A5, a[0], "R6");
    rd_all("R5 R6 first pass");
    for (int a = 0; a < 64; a += 3)
      program_word(6'(a), ~16'(a * 16'h0F0F), a[1], "R6");
    rd_all("R6 and pass");

    // R7 erase block 2 via address inside the block
    erase_blk(6'd37);
    rd_all("R7");

    // R8 aborted erase
    bus_wr(6'd5, 16'h0020, 1'b0);
    bus_wr(6'd5, 16'h00AB, 1'b1);
    repeat (10) @(negedge clk);
    chk("R8 busy", busy, 0);
    rd_all("R8");

    // R12 unrecognised code, upper byte set
    bus_wr(6'd9, 16'h3412, 1'b0);
    bus_wr(6'd9, 16'h00FF, 1'b1);
    repeat (6) @(negedge clk);
    rd_all("R12");

    // R10 write during erase ignored
    bus_wr(6'd48, 16'h0020, 1'b0);
    bus_wr(6'd48, 16'h00D0, 1'b0);
    for (int w = 48; w < 64; w++) exp_mem[w] = 16'hFFFF;
    bus_wr(6'd50, 16'h0040, 1'b1);
    wait_busy(-1, "R10", s);
    bus_wr(6'd50, 16'h0000, 1'b0);
    repeat (6) @(negedge clk);
    chk("R10 busy", busy, 0);
    rd(6'd50, "R10");
    rd_all("R10");

    // R11 deselect during erase, oe held low
    bus_wr(6'd20, 16'h0020, 1'b0);
    bus_wr(6'd20, 16'h00D0, 1'b1);
    oe_n = 1'b0;
    wait_busy(16, "R11 length", s);
    chk("R11 standby oe", s, 0);
    oe_n = 1'b1;
    for (int w = 16; w < 32; w++) exp_mem[w] = 16'hFFFF;
    rd_all("R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule